// File: doc/BRIEF.md
# Three-Stage Pipelined Integer Core

A small in-order processor that overlaps three stages: fetch, decode with register read, and execute with writeback. One instruction enters fetch every cycle. It runs a compact 16-bit instruction set over eight 16-bit registers. The set has register-register and immediate ALU operations, a compare that sets four flags, a byte load from a small internal data memory, PC-relative conditional branches and a halt. Every instruction carries a 3-bit condition field and executes only when that condition holds against the current flags. An instruction whose condition fails still uses its pipeline slot.

Operands read in decode can be stale, because the instruction ahead writes back only at the end of execute. The core does not stall for this. It forwards the execute result into the operand latched by decode. Branches are resolved at the end of execute while fetch keeps going sequentially. A taken branch turns the two younger instructions into bubbles and sends fetch to the target. Both memories are written through load ports while reset is held. The register file and the PC can be observed from outside, and a done flag marks the point at which the final state can be compared.

Top module: `pipe3_core`

## Requirements
- R1: While reset is high, and just after it, pc reads 0 and done reads 0. Every register reads 0 through the observation port.
- R2: Field layout: op=[15:12] and cond=[11:9]. R-type ops use rd=[8:6], rs=[5:3] and rt=[2:0]. The op codes are 1 ADD, 2 SUB, 3 AND, 4 OR and 5 XOR, each computing rd = rs op rt. Op 6 MOVI sets rd = sign-extended [5:0]. Op 7 ADDI sets rd = rd + sign-extended [5:0]. Op 0 is a no-op.
- R3: When an instruction reads a register written by the instruction directly ahead of it, it gets the new value with no stall. This holds for ALU and load results alike, and register 0 behaves like any other register.
- R4: Op 8 CMP (rs=[5:3], rt=[2:0]) sets the zero, negative, carry and overflow flags from rs - rt, with carry meaning no borrow. The cond codes are 0 always, 1 eq, 2 ne, 3 gt (Z=0 and N=V), 4 lt (N!=V), 5 ge (N=V), 6 le (Z=1 or N!=V) and 7 never. The instruction directly after a CMP sees the new flags.
- R5: An instruction whose condition fails writes neither a register nor the flags. This applies to a CMP as well.
- R6: Op 10 BR with a signed 9-bit offset [8:0] jumps to its own address plus the offset when its condition holds. The two instructions that follow it in sequence have no effect. A taken branch costs two cycles.
- R7: A BR whose condition fails falls through to the next address and costs no cycles.
- R8: Op 9 LDB (rd, rs, imm=[2:0] unsigned) loads the zero-extended data byte at address rs + imm into rd.
- R9: Op 15 HALT raises done once it reaches execute. From then on pc and done stay fixed, and the instructions after the halt have no effect.
- R10: Without taken branches, a HALT at address k raises done after the (k+3)-th rising edge following reset release. At that point pc reads k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction memory write enable |
| imem_addr | input | 6 | Instruction memory write address |
| imem_wdata | input | 16 | Instruction word to write |
| dmem_we | input | 1 | Data memory write enable |
| dmem_addr | input | 4 | Data memory write address |
| dmem_wdata | input | 8 | Data byte to write |
| dbg_sel | input | 3 | Register selected for observation |
| dbg_data | output | 16 | Value of the selected register |
| pc | output | 6 | Current fetch address |
| done | output | 1 | High once a HALT has executed |

## Verification
A bad forwarding path or bad flag state shows up in the final register values. It does not change the pc or the done cycle. Such errors are caught by comparing the registers after the halt against values worked out by hand. A wrong squash or a wrong branch target changes both the registers and the cycle on which done rises, and that cycle is checked exactly. A core that fails to freeze after the halt shows a changing pc, or a late register write, within one cycle of done.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;

    localparam int DW   = 16;
    localparam int IW   = 16;
    localparam int NREG = 8;
    localparam int RAW  = $clog2(NREG);

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_MOVI = 4'd6,
        OP_ADDI = 4'd7,
        OP_CMP  = 4'd8,
        OP_LDB  = 4'd9,
        OP_BR   = 4'd10,
        OP_HALT = 4'd15
    } op_e;

    typedef enum logic [2:0] {
        C_AL = 3'd0,
        C_EQ = 3'd1,
        C_NE = 3'd2,
        C_GT = 3'd3,
        C_LT = 3'd4,
        C_GE = 3'd5,
        C_LE = 3'd6,
        C_NV = 3'd7
    } cond_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        op_e             op;
        cond_e           cond;
        logic [RAW-1:0]  rd;
        logic [RAW-1:0]  rs;
        logic [RAW-1:0]  rt;
        logic [DW-1:0]   imm;
        logic            wr;
    } dec_t;

    function automatic logic cond_ok(cond_e c, flags_t f);
        case (c)
            C_AL:    return 1'b1;
            C_EQ:    return f.z;
            C_NE:    return !f.z;
            C_GT:    return !f.z && (f.n == f.v);
            C_LT:    return f.n != f.v;
            C_GE:    return f.n == f.v;
            C_LE:    return f.z || (f.n != f.v);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pipe3_decode.sv
module pipe3_decode
    import pipe3_pkg::*;
(
    input  logic [IW-1:0] instr,
    output dec_t          dec
);
    always_comb begin
        dec.op   = OP_NOP;
        dec.cond = cond_e'(instr[11:9]);
        dec.rd   = instr[8:6];
        dec.rs   = instr[5:3];
        dec.rt   = instr[2:0];
        dec.imm  = '0;
        dec.wr   = 1'b0;
        case (instr[15:12])
            4'd1, 4'd2, 4'd3, 4'd4, 4'd5: begin
                dec.op = op_e'(instr[15:12]);
                dec.wr = 1'b1;
            end
            4'd6: begin
                dec.op  = OP_MOVI;
                dec.wr  = 1'b1;
                dec.imm = {{(DW-6){instr[5]}}, instr[5:0]};
            end
            4'd7: begin
                dec.op  = OP_ADDI;
                dec.wr  = 1'b1;
                dec.rs  = instr[8:6];
                dec.imm = {{(DW-6){instr[5]}}, instr[5:0]};
            end
            4'd8: dec.op = OP_CMP;
            4'd9: begin
                dec.op  = OP_LDB;
                dec.wr  = 1'b1;
                dec.imm = {{(DW-3){1'b0}}, instr[2:0]};
            end
            4'd10: begin
                dec.op  = OP_BR;
                dec.imm = {{(DW-9){instr[8]}}, instr[8:0]};
            end
            4'd15: dec.op = OP_HALT;
            default: dec.op = OP_NOP;
        endcase
    end
endmodule

// File: rtl/pipe3_regfile.sv
module pipe3_regfile
    import pipe3_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [RAW-1:0] ra_addr,
    input  logic [RAW-1:0] rb_addr,
    input  logic [RAW-1:0] rc_addr,
    output logic [DW-1:0]  ra,
    output logic [DW-1:0]  rb,
    output logic [DW-1:0]  rc
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign ra = regs[ra_addr];
    assign rb = regs[rb_addr];
    assign rc = regs[rc_addr];
endmodule

// File: rtl/pipe3_exec.sv
module pipe3_exec
    import pipe3_pkg::*;
#(
    parameter int PAW  = 6,
    parameter int DMAW = 4
) (
    input  logic            valid,
    input  logic            halted,
    input  op_e             op,
    input  cond_e           cond,
    input  logic            wr,
    input  logic [DW-1:0]   imm,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic [PAW-1:0]  pc,
    input  flags_t          flags_q,
    input  logic [7:0]      dm_rdata,
    output logic [DMAW-1:0] dm_raddr,
    output logic [DW-1:0]   result,
    output logic            wr_en,
    output logic            flag_we,
    output flags_t          flags_new,
    output logic            taken,
    output logic [PAW-1:0]  target,
    output logic            halt
);
    logic          pass;
    logic [DW:0]   diff;

    always_comb begin
        pass = valid && !halted && cond_ok(cond, flags_q);
        diff = {1'b0, a} - {1'b0, b};
        case (op)
            OP_ADD:  result = a + b;
            OP_SUB:  result = a - b;
            OP_AND:  result = a & b;
            OP_OR:   result = a | b;
            OP_XOR:  result = a ^ b;
            OP_MOVI: result = imm;
            OP_ADDI: result = a + imm;
            OP_LDB:  result = {{(DW-8){1'b0}}, dm_rdata};
            default: result = '0;
        endcase
        flags_new.z = (diff[DW-1:0] == '0);
        flags_new.n = diff[DW-1];
        flags_new.c = !diff[DW];
        flags_new.v = (a[DW-1] != b[DW-1]) && (diff[DW-1] != a[DW-1]);
        wr_en   = pass && wr;
        flag_we = pass && (op == OP_CMP);
        taken   = pass && (op == OP_BR);
        halt    = pass && (op == OP_HALT);
    end

    assign dm_raddr = DMAW'(a) + DMAW'(imm);
    assign target   = pc + PAW'(imm);
endmodule

// File: rtl/pipe3_core.sv
module pipe3_core
    import pipe3_pkg::*;
#(
    parameter int IM_DEPTH = 64,
    parameter int DM_DEPTH = 16,
    localparam int PAW  = $clog2(IM_DEPTH),
    localparam int DMAW = $clog2(DM_DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            imem_we,
    input  logic [PAW-1:0]  imem_addr,
    input  logic [IW-1:0]   imem_wdata,
    input  logic            dmem_we,
    input  logic [DMAW-1:0] dmem_addr,
    input  logic [7:0]      dmem_wdata,
    input  logic [RAW-1:0]  dbg_sel,
    output logic [DW-1:0]   dbg_data,
    output logic [PAW-1:0]  pc,
    output logic            done
);
    logic [IW-1:0] imem [IM_DEPTH];
    logic [7:0]    dmem [DM_DEPTH];

    logic [PAW-1:0] pc_q;
    logic           ifid_valid;
    logic [IW-1:0]  ifid_instr;
    logic [PAW-1:0] ifid_pc;

    logic           idex_valid;
    logic [PAW-1:0] idex_pc;
    op_e            idex_op;
    cond_e          idex_cond;
    logic [RAW-1:0] idex_rd;
    logic           idex_wr;
    logic [DW-1:0]  idex_imm;
    logic [DW-1:0]  idex_a;
    logic [DW-1:0]  idex_b;

    flags_t         flags_q;
    logic           done_q;

    dec_t           id_dec;
    logic [DW-1:0]  rf_a, rf_b, id_a, id_b;

    logic [DMAW-1:0] ex_dm_addr;
    logic [DW-1:0]   ex_result;
    logic            ex_wr_en, ex_flag_we, ex_taken, ex_halt;
    flags_t          ex_flags;
    logic [PAW-1:0]  ex_target;
    logic            flush;

    always_ff @(posedge clk) begin
        if (imem_we) imem[imem_addr] <= imem_wdata;
        if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    end

    pipe3_decode u_dec (
        .instr (ifid_instr),
        .dec   (id_dec)
    );

    pipe3_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (ex_wr_en),
        .waddr   (idex_rd),
        .wdata   (ex_result),
        .ra_addr (id_dec.rs),
        .rb_addr (id_dec.rt),
        .rc_addr (dbg_sel),
        .ra      (rf_a),
        .rb      (rf_b),
        .rc      (dbg_data)
    );

    // execute-to-decode bypass: the value written this cycle replaces the stale read
    assign id_a = (ex_wr_en && idex_rd == id_dec.rs) ? ex_result : rf_a;
    assign id_b = (ex_wr_en && idex_rd == id_dec.rt) ? ex_result : rf_b;

    pipe3_exec #(.PAW(PAW), .DMAW(DMAW)) u_ex (
        .valid     (idex_valid),
        .halted    (done_q),
        .op        (idex_op),
        .cond      (idex_cond),
        .wr        (idex_wr),
        .imm       (idex_imm),
        .a         (idex_a),
        .b         (idex_b),
        .pc        (idex_pc),
        .flags_q   (flags_q),
        .dm_rdata  (dmem[ex_dm_addr]),
        .dm_raddr  (ex_dm_addr),
        .result    (ex_result),
        .wr_en     (ex_wr_en),
        .flag_we   (ex_flag_we),
        .flags_new (ex_flags),
        .taken     (ex_taken),
        .target    (ex_target),
        .halt      (ex_halt)
    );

    assign flush = ex_taken || ex_halt || done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= '0;
            ifid_valid <= 1'b0;
            ifid_instr <= '0;
            ifid_pc    <= '0;
            idex_valid <= 1'b0;
            idex_pc    <= '0;
            idex_op    <= OP_NOP;
            idex_cond  <= C_AL;
            idex_rd    <= '0;
            idex_wr    <= 1'b0;
            idex_imm   <= '0;
            idex_a     <= '0;
            idex_b     <= '0;
            flags_q    <= '0;
            done_q     <= 1'b0;
        end else begin
            ifid_valid <= !flush;
            ifid_instr <= imem[pc_q];
            ifid_pc    <= pc_q;
            idex_valid <= ifid_valid && !flush;
            idex_pc    <= ifid_pc;
            idex_op    <= id_dec.op;
            idex_cond  <= id_dec.cond;
            idex_rd    <= id_dec.rd;
            idex_wr    <= id_dec.wr;
            idex_imm   <= id_dec.imm;
            idex_a     <= id_a;
            idex_b     <= id_b;
            if (ex_taken)
                pc_q <= ex_target;
            else if (!(ex_halt || done_q))
                pc_q <= pc_q + PAW'(1);
            if (ex_flag_we) flags_q <= ex_flags;
            if (ex_halt) done_q <= 1'b1;
        end
    end

    assign pc   = pc_q;
    assign done = done_q;
endmodule

// File: rtl/pipe3_checker.sv
module pipe3_checker #(
    parameter int PAW = 6
) (
    input logic           clk,
    input logic           rst,
    input logic [PAW-1:0] pc,
    input logic           done,
    input logic           ex_taken,
    input logic           ex_halt,
    input logic           rf_we,
    input logic           flag_we,
    input logic           ifid_valid,
    input logic           idex_valid
);
    AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && $stable(pc))); // R9

    AST_NO_EFFECT_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!rf_we && !flag_we && !ex_taken)); // R9

    AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (rst)
        (!ex_taken && !ex_halt && !done) |=> (pc == $past(pc) + PAW'(1))); // R10

    AST_SQUASH_YOUNGER: assert property (@(posedge clk) disable iff (rst)
        ex_taken |=> (!ifid_valid && !idex_valid)); // R6

    AST_ONE_EFFECT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ex_taken, ex_halt, rf_we, flag_we})); // R2
endmodule

bind pipe3_core pipe3_checker #(.PAW(PAW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc         (pc),
    .done       (done),
    .ex_taken   (ex_taken),
    .ex_halt    (ex_halt),
    .rf_we      (ex_wr_en),
    .flag_we    (ex_flag_we),
    .ifid_valid (ifid_valid),
    .idex_valid (idex_valid)
);

// File: tb/pipe3_core_test.sv
`timescale 1ns/1ps
module pipe3_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_addr = '0;
    logic [15:0] imem_wdata = '0;
    logic        dmem_we = 1'b0;
    logic [3:0]  dmem_addr = '0;
    logic [7:0]  dmem_wdata = '0;
    logic [2:0]  dbg_sel = '0;
    logic [15:0] dbg_data;
    logic [5:0]  pc;
    logic        done;

    int checks = 0;
    int errors = 0;

    localparam logic [2:0] AL = 3'd0, EQ = 3'd1, NE = 3'd2, GT = 3'd3,
                           LT = 3'd4, GE = 3'd5, LE = 3'd6;

    // program one expectations: {register, value, requirement number}
    localparam logic [22:0] EXP [8] = '{
        {3'd0, 16'h014A, 4'd3},   // R3 load result forwarded, r0 ordinary
        {3'd1, 16'h0005, 4'd6},   // R6 squashed MOVI r1 and post-halt write
        {3'd2, 16'h0003, 4'd6},   // R6 squashed MOVI r2
        {3'd3, 16'h0008, 4'd2},   // R2 ADD
        {3'd4, 16'h0001, 4'd7},   // R7 fall-through ADDI after untaken BR
        {3'd5, 16'h000A, 4'd5},   // R5 failed ADDI.le leaves r5
        {3'd6, 16'h0009, 4'd4},   // R4 lt after CMP, failed CMP kept flags
        {3'd7, 16'h00A5, 4'd8}    // R8 byte load
    };

    pipe3_core uut (
        .clk(clk), .rst(rst),
        .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
        .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dbg_sel(dbg_sel), .dbg_data(dbg_data), .pc(pc), .done(done)
    );

    always #2.5 clk = ~clk;

    function automatic logic [15:0] rr(input logic [3:0] op, input logic [2:0] c,
                                       input logic [2:0] d, input logic [2:0] s,
                                       input logic [2:0] t);
        return {op, c, d, s, t};
    endfunction

    function automatic logic [15:0] mi(input logic [3:0] op, input logic [2:0] c,
                                       input logic [2:0] d, input logic [5:0] imm);
        return {op, c, d, imm};
    endfunction

    function automatic logic [15:0] br(input logic [2:0] c, input logic [8:0] off);
        return {4'hA, c, off};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic im(input int a, input logic [15:0] w);
        @(negedge clk);
        imem_we = 1'b1; imem_addr = a[5:0]; imem_wdata = w;
        @(negedge clk);
        imem_we = 1'b0;
    endtask

    task automatic dm(input int a, input logic [7:0] w);
        @(negedge clk);
        dmem_we = 1'b1; dmem_addr = a[3:0]; dmem_wdata = w;
        @(negedge clk);
        dmem_we = 1'b0;
    endtask

    task automatic start_load();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 64; i++) im(i, 16'h0000);
    endtask

    task automatic run(output int cyc);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    function automatic logic [15:0] rd_reg(input logic [2:0] r);
        return 16'h0;
    endfunction

    task automatic peek(input logic [2:0] r, output logic [15:0] v);
        dbg_sel = r;
        #0.5;
        v = dbg_data;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cyc;
        logic [15:0] v;

        // ---------------- program one: mixed function
        start_load();
        im(0,  mi(4'd6, AL, 3'd1, 6'd5));
        im(1,  mi(4'd6, AL, 3'd2, 6'd3));
        im(2,  rr(4'd1, AL, 3'd3, 3'd1, 3'd2));
        im(3,  rr(4'd2, AL, 3'd4, 3'd3, 3'd1));
        im(4,  rr(4'd8, AL, 3'd0, 3'd1, 3'd2));
        im(5,  rr(4'd1, GT, 3'd5, 3'd1, 3'd1));
        im(6,  mi(4'd6, EQ, 3'd6, 6'd7));
        im(7,  mi(4'd6, LT, 3'd6, 6'd9));
        im(8,  mi(4'd7, LE, 3'd5, 6'd1));
        im(9,  rr(4'd8, AL, 3'd0, 3'd2, 3'd1));
        im(10, rr(4'd8, EQ, 3'd0, 3'd1, 3'd1));
        im(11, mi(4'd6, LT, 3'd6, 6'd9));
        im(12, rr(4'd9, AL, 3'd7, 3'd2, 3'd1));
        im(13, rr(4'd1, AL, 3'd0, 3'd7, 3'd7));
        im(14, br(NE, 9'd3));
        im(15, mi(4'd6, AL, 3'd1, 6'd31));
        im(16, mi(4'd6, AL, 3'd2, 6'd31));
        im(17, br(EQ, 9'd5));
        im(18, mi(4'd7, AL, 3'd4, 6'h3E));
        im(19, 16'hF000);
        im(20, mi(4'd6, AL, 3'd1, 6'd1));
        im(21, mi(4'd6, AL, 3'd2, 6'd1));
        dm(3, 8'h11);
        dm(4, 8'hA5);
        dm(5, 8'h22);
        run(cyc);
        chk("R10 done cycle, program one", cyc, 22);
        chk("R9 pc at halt, program one", pc, 21);
        for (int i = 0; i < 8; i++) begin
            peek(EXP[i][22:20], v);
            chk($sformatf("R%0d register r%0d", EXP[i][3:0], EXP[i][22:20]),
                v, EXP[i][19:4]);
        end

        // ---------------- reset state (R1), then program two: timing and halt
        start_load();
        chk("R1 pc in reset", pc, 0);
        chk("R1 done in reset", done, 0);
        for (int r = 0; r < 8; r++) begin
            peek(r[2:0], v);
            chk($sformatf("R1 register r%0d cleared", r), v, 0);
        end
        im(0, mi(4'd6, AL, 3'd1, 6'd1));
        im(1, mi(4'd6, AL, 3'd2, 6'd2));
        im(2, mi(4'd6, AL, 3'd3, 6'd3));
        im(3, mi(4'd6, AL, 3'd4, 6'd4));
        im(4, 16'hF000);
        im(5, mi(4'd6, AL, 3'd1, 6'd20));
        im(6, mi(4'd6, AL, 3'd2, 6'd21));
        run(cyc);
        chk("R10 done cycle for halt at 4", cyc, 7);
        chk("R10 pc at done", pc, 6);
        repeat (5) @(negedge clk);
        chk("R9 pc frozen", pc, 6);
        chk("R9 done held", done, 1);
        peek(3'd1, v);
        chk("R9 no write after halt r1", v, 1);
        peek(3'd2, v);
        chk("R9 no write after halt r2", v, 2);
        peek(3'd4, v);
        chk("R2 MOVI r4", v, 4);

        // ---------------- program three: backward loop
        start_load();
        im(0, mi(4'd6, AL, 3'd1, 6'd0));
        im(1, mi(4'd6, AL, 3'd2, 6'd3));
        im(2, mi(4'd7, AL, 3'd1, 6'd1));
        im(3, rr(4'd8, AL, 3'd0, 3'd1, 3'd2));
        im(4, br(LT, 9'h1FE));
        im(5, 16'hF000);
        run(cyc);
        chk("R6 two cycles per taken branch", cyc, 18);
        chk("R6 pc after loop halt", pc, 7);
        peek(3'd1, v);
        chk("R6 backward loop count r1", v, 3);
        peek(3'd2, v);
        chk("R4 ge exit leaves r2", v, 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule